// File: doc/BRIEF.md
# Pipelined Goldschmidt Convergence Divider

This block divides one normalized fixed-point significand by another. Both operands lie in [1,2), so the quotient lies in (0.5,2). The block uses the Goldschmidt method. A registered seed table holds reciprocal estimates and supplies the first scale factor. Every later factor is the two's complement of the current scaled divisor. Each factor multiplies the dividend path and the divisor path alike, so the divisor approaches one and the dividend approaches the quotient. The error shrinks quadratically with each step.

All seven products of a division go through one shared multiplier. That multiplier has a fixed latency of four cycles and accepts a new product every cycle. A fixed issue schedule sends each product into the multiplier in the cycle its operand leaves the pipeline. This leaves holes in the pipeline, and a second independent division can run in them. It must be offered exactly two cycles after the first. A requester raises `start` with stable operands and keeps it raised until `take` is high. Results come out in the order the divisions were accepted.

Top module: `gdiv_top`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) drives `done` low and `quotient` to zero, drops any division in flight so that it never reports, and leaves the block idle.
- R2: Operands are unsigned Q1.(W-1) values with the most significant bit set. The quotient is reported in the same format. It differs from floor(dividend·2^(W-1)/divisor) by no more than two units below and one unit above.
- R3: `done` is high for exactly one cycle: the 20th cycle after the cycle in which `take` was high. `quotient` carries the result in that cycle and holds it until the next result.
- R4: With no division in flight, `take` equals `start` in the same cycle.
- R5: A request is taken when it comes exactly two cycles after the acceptance of a division that runs alone. Its result arrives two cycles after the result of the first division.
- R6: Any other request made while a division is in flight sees `take` low. A held request is taken in the cycle in which the result of the last division in flight is reported.
- R7: No two divisions ever issue a product to the shared multiplier in the same cycle, and interleaved divisions give the same results as they would alone.
- R8: Each product is read in the cycle it leaves the four-stage multiplier. The seed table has 2^SEED_BITS entries, addressed by the SEED_BITS divisor bits just below its leading one.
- R9: Operands are sampled only in the accepting cycle, and later changes on `dividend` or `divisor` do not affect that division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Division request, held until taken |
| dividend | input | W | Numerator, Q1.(W-1), MSB set |
| divisor | input | W | Denominator, Q1.(W-1), MSB set |
| take | output | 1 | Request accepted this cycle (combinational from `start` and state) |
| quotient | output | W | Registered quotient, Q1.(W-1) |
| done | output | 1 | Registered one-cycle result strobe |

## Verification
`take` answers in the same cycle as the request. `done` and `quotient` are due 20 cycles after the accepting cycle, and an interleaved second result is due 22 cycles after the first acceptance. The bench changes inputs on falling edges and counts falling edges from the accepting cycle. It checks `done` low in the cycle before the due cycle, high in the due cycle and low again after it. Refusal windows are checked cycle by cycle until the exact cycle in which the held request must be taken.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

  // Which operand pair a job slot drives into the shared multiplier.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SEED_DIVISOR,
    SEL_SEED_DIVIDEND,
    SEL_STEP_FRESH,
    SEL_STEP_HELD
  } op_sel_e;

  // Rounded reciprocal of the midpoint of table interval idx, with frac_bits fraction bits.
  // Interval idx covers divisors 1 + idx/2^idx_bits .. 1 + (idx+1)/2^idx_bits.
  function automatic logic [63:0] seed_value(input int unsigned idx,
                                             input int unsigned idx_bits,
                                             input int unsigned frac_bits);
    logic [63:0] num;
    logic [63:0] den;
    num = 64'd1 << (frac_bits + idx_bits + 1);
    den = (64'd1 << (idx_bits + 1)) + 64'(2 * idx + 1);
    return (num + (den >> 1)) / den;
  endfunction

endpackage

// File: rtl/gdiv_seed_rom.sv
module gdiv_seed_rom #(
  parameter int IDX_BITS = 6,
  parameter int IW       = 30
) (
  input  logic                clk,
  input  logic                rd_en,
  input  logic [IDX_BITS-1:0] addr,
  output logic [IW-1:0]       q
);
  localparam int DEPTH = 1 << IDX_BITS;
  localparam int FRAC  = IW - 1;

  logic [IW-1:0] mem [DEPTH];

  // Contents computed at elaboration; synchronous read so it maps to block RAM.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [63:0] v;
      v = gdiv_pkg::seed_value(i, IDX_BITS, FRAC);
      mem[i] = v[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end
endmodule

// File: rtl/gdiv_mul_pipe.sv
module gdiv_mul_pipe #(
  parameter int IW  = 30,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [IW-1:0] in_a,
  input  logic [IW-1:0] in_b,
  output logic          out_valid,
  output logic [IW-1:0] out_p
);
  localparam int PW = 2 * IW;
  localparam int F  = IW - 1;

  logic [PW-1:0] full;
  logic [IW-1:0] keep;
  logic          rnd;
  logic [IW:0]   sum;
  logic [IW-1:0] res;

  // Q1.F x Q1.F -> Q2.2F, rounded to nearest-even back to Q1.F, saturating at 2.
  always_comb begin
    full = PW'(in_a) * PW'(in_b);
    keep = full[PW-2:F];
    rnd  = full[F-1] & ((|full[F-2:0]) | full[F]);
    sum  = {1'b0, keep} + (IW+1)'(rnd);
    res  = (full[PW-1] | sum[IW]) ? {IW{1'b1}} : sum[IW-1:0];
  end

  logic [IW-1:0] stg [LAT];
  logic [LAT-1:0] vld;

  always_ff @(posedge clk) begin
    stg[0] <= res;
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= in_valid;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stg[s] <= stg[s-1];
      if (rst) vld[s] <= 1'b0;
      else     vld[s] <= vld[s-1];
    end
  end

  assign out_p     = stg[LAT-1];
  assign out_valid = vld[LAT-1];
endmodule

// File: rtl/gdiv_slot.sv
module gdiv_slot
  import gdiv_pkg::*;
#(
  parameter int W   = 24,
  parameter int IW  = 30,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [IW-1:0] seed_in,
  input  logic [IW-1:0] prod,
  input  logic          prod_valid,
  output logic          busy,
  output logic          join_open,
  output logic          issue,
  output logic [IW-1:0] op_a,
  output logic [IW-1:0] op_b,
  output logic          finish
);
  localparam int G       = IW - W;
  // Job age: 1 in the cycle after acceptance (seed ready), then counting.
  localparam int T_M1    = 2;              // divisor x seed
  localparam int T_M2    = 3;              // dividend x seed
  localparam int T_S1    = T_M1 + LAT;     // first complement step, divisor path
  localparam int T_S2    = T_M1 + 2 * LAT; // second complement step, divisor path
  localparam int T_LK    = T_M1 + 3 * LAT; // last factor captured, no issue
  localparam int T_M7    = T_LK + 1;       // final dividend product
  localparam int T_END   = T_M7 + LAT;     // quotient leaves the pipe
  localparam int AW      = $clog2(T_END + 1);

  logic [AW-1:0] age;
  logic [IW-1:0] a_r, b_r, seed_r, k_r;
  logic [IW-1:0] neg_prod;
  op_sel_e       sel;
  logic          grab_k;
  logic          uses_prod;

  always_ff @(posedge clk) begin
    if (rst)                      age <= '0;
    else if (load)                age <= AW'(1);
    else if (age == AW'(T_END))   age <= '0;
    else if (age != '0)           age <= age + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_r <= {a_in, {G{1'b0}}};
      b_r <= {b_in, {G{1'b0}}};
    end
    if (age == AW'(1)) seed_r <= seed_in;
    if (grab_k)        k_r    <= neg_prod;
  end

  // Two's complement of a scaled divisor in Q1.F is 2 minus its value.
  assign neg_prod = -prod;

  always_comb begin
    sel    = SEL_NONE;
    grab_k = 1'b0;
    if (age == AW'(T_M1))                         sel = SEL_SEED_DIVISOR;
    else if (age == AW'(T_M2))                    sel = SEL_SEED_DIVIDEND;
    else if (age == AW'(T_S1) || age == AW'(T_S2)) begin
      sel    = SEL_STEP_FRESH;
      grab_k = 1'b1;
    end
    else if (age == AW'(T_S1 + 1) || age == AW'(T_S2 + 1) || age == AW'(T_M7))
                                                  sel = SEL_STEP_HELD;
    else if (age == AW'(T_LK))                    grab_k = 1'b1;
  end

  always_comb begin
    op_a = prod;
    op_b = k_r;
    unique case (sel)
      SEL_SEED_DIVISOR:  begin op_a = b_r;  op_b = seed_r;   end
      SEL_SEED_DIVIDEND: begin op_a = a_r;  op_b = seed_r;   end
      SEL_STEP_FRESH:    begin op_a = prod; op_b = neg_prod; end
      SEL_STEP_HELD:     begin op_a = prod; op_b = k_r;      end
      default:           begin op_a = prod; op_b = k_r;      end
    endcase
  end

  assign issue     = (sel != SEL_NONE);
  assign busy      = (age != '0);
  assign join_open = (age == AW'(2));
  assign finish    = (age == AW'(T_END));
  assign uses_prod = (sel == SEL_STEP_FRESH) || (sel == SEL_STEP_HELD) || grab_k || finish;

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy); // R6
  AST_NORM_INPUTS: assert property (@(posedge clk) disable iff (rst)
    load |-> (a_in[W-1] && b_in[W-1])); // R2
  AST_PROD_FRESH: assert property (@(posedge clk) disable iff (rst)
    uses_prod |-> prod_valid); // R8
endmodule

// File: rtl/gdiv_top.sv
module gdiv_top #(
  parameter int W         = 24,
  parameter int GUARD     = 6,
  parameter int SEED_BITS = 6,
  parameter int LAT       = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         take,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int IW    = W + GUARD;
  localparam int SLOTS = 2;

  logic [SLOTS-1:0] busy, join_open, issue, finish, load;
  logic [IW-1:0]    op_a [SLOTS];
  logic [IW-1:0]    op_b [SLOTS];
  logic [IW-1:0]    seed_q;
  logic [IW-1:0]    prod;
  logic             prod_valid;
  logic [IW-1:0]    mul_a, mul_b;
  logic             mul_v;
  logic             free_all, join_ok;

  // Accept when idle, or in the join cycle of a lone division.
  always_comb begin
    free_all = (busy == '0);
    join_ok  = (busy[0] && join_open[0] && !busy[1]) ||
               (busy[1] && join_open[1] && !busy[0]);
    take     = start && (free_all || join_ok);
    load[0]  = take && !busy[0];
    load[1]  = take && busy[0];
  end

  gdiv_seed_rom #(.IDX_BITS(SEED_BITS), .IW(IW)) u_rom (
    .clk   (clk),
    .rd_en (take),
    .addr  (divisor[W-2 -: SEED_BITS]),
    .q     (seed_q)
  );

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    gdiv_slot #(.W(W), .IW(IW), .LAT(LAT)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .load       (load[j]),
      .a_in       (dividend),
      .b_in       (divisor),
      .seed_in    (seed_q),
      .prod       (prod),
      .prod_valid (prod_valid),
      .busy       (busy[j]),
      .join_open  (join_open[j]),
      .issue      (issue[j]),
      .op_a       (op_a[j]),
      .op_b       (op_b[j]),
      .finish     (finish[j])
    );
  end

  always_comb begin
    mul_v = |issue;
    mul_a = issue[0] ? op_a[0] : op_a[1];
    mul_b = issue[0] ? op_b[0] : op_b[1];
  end

  gdiv_mul_pipe #(.IW(IW), .LAT(LAT)) u_mul (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (mul_v),
    .in_a      (mul_a),
    .in_b      (mul_b),
    .out_valid (prod_valid),
    .out_p     (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= |finish;
      if (|finish) quotient <= prod[IW-1 -: W];
    end
  end

  AST_ONE_ISSUER: assert property (@(posedge clk) disable iff (rst)
    !(issue[0] && issue[1])); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
endmodule

// File: tb/gdiv_top_test.sv
`timescale 1ns/1ps
module gdiv_top_test;
  localparam int W = 24;
  localparam logic [W-1:0] MSB = 24'h800000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dvd = MSB;
  logic [W-1:0] dvs = MSB;
  logic         take;
  logic [W-1:0] quotient;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  gdiv_top uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dvd), .divisor(dvs),
    .take(take), .quotient(quotient), .done(done)
  );

  localparam logic [47:0] VEC [8] = '{
    {24'h800000, 24'h800000},
    {24'hFFFFFF, 24'h800000},
    {24'h800000, 24'hFFFFFF},
    {24'hC00000, 24'hA00000},
    {24'hB504F3, 24'h9E3779},
    {24'hFFFFFF, 24'hFFFFFF},
    {24'h812345, 24'hFEDCBA},
    {24'hAAAAAA, 24'hD55555}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic longint exp_q(input logic [W-1:0] a, input logic [W-1:0] b);
    return (longint'(a) << (W - 1)) / longint'(b);
  endfunction

  task automatic check_q(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    longint e;
    longint q;
    e = exp_q(a, b);
    q = longint'(quotient);
    check((q + 2 >= e) && (q <= e + 1), tag, q, e);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // One lone division; returns at the cycle after its result.
  task automatic do_single(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); dvd = a; dvs = b; start = 1'b1; #1;
    check(take == 1'b1, "R4 take while idle", take, 1);
    @(negedge clk); start = 1'b0; dvd = ~a | MSB; dvs = ~b | MSB;
    repeat (18) @(negedge clk);
    check(done == 1'b0, "R3 done not early", done, 0);
    @(negedge clk);
    check(done == 1'b1, "R3 done on cycle 20", done, 1);
    check_q(a, b, "R2/R8/R9 quotient");
    @(negedge clk);
    check(done == 1'b0, "R3 done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(quotient == '0, "R1 quotient after reset", quotient, 0);
    check(take == 1'b0, "R4 no take without start", take, 0);

    // Vector table, one lone division each
    for (int i = 0; i < 8; i++) do_single(VEC[i][47:24], VEC[i][23:0]);

    // R5/R6/R7: interleaved pair, then a held third request
    @(negedge clk); dvd = 24'hE00000; dvs = 24'h900000; start = 1'b1; #1;
    check(take == 1'b1, "R4 first of pair taken", take, 1);
    @(negedge clk); dvd = 24'h9ABCDE; dvs = 24'hC3C3C3; #1;
    check(take == 1'b0, "R6 request one cycle after accept refused", take, 0);
    @(negedge clk); #1;
    check(take == 1'b1, "R5 join two cycles after accept", take, 1);
    @(negedge clk); start = 1'b0; dvd = 24'hFFFFFF; dvs = 24'h800001;
    for (int n = 4; n <= 22; n++) begin
      @(negedge clk);
      if (n == 4) begin dvd = 24'hF0F0F0; dvs = 24'h8F8F8F; start = 1'b1; end
      #1;
      if (n < 22) check(take == 1'b0, "R6 refused while pair in flight", take, 0);
      else        check(take == 1'b1, "R6 taken when last result reports", take, 1);
      if (n == 20) begin
        check(done == 1'b1, "R5 first result on cycle 20", done, 1);
        check_q(24'hE00000, 24'h900000, "R5/R7 first quotient");
      end
      if (n == 21) check(done == 1'b0, "R5 gap between results", done, 0);
      if (n == 22) begin
        check(done == 1'b1, "R5 second result on cycle 22", done, 1);
        check_q(24'h9ABCDE, 24'hC3C3C3, "R5/R7 second quotient");
      end
    end
    @(negedge clk); start = 1'b0; dvd = MSB; dvs = MSB;
    repeat (19) @(negedge clk);
    check(done == 1'b1, "R6 held request result", done, 1);
    check_q(24'hF0F0F0, 24'h8F8F8F, "R6 held quotient");

    // R6: late request on a lone division waits for its result
    @(negedge clk); dvd = 24'hC90FDB; dvs = 24'hADF854; start = 1'b1; #1;
    check(take == 1'b1, "R4 lone accept", take, 1);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    for (int n = 3; n <= 20; n++) begin
      @(negedge clk);
      if (n == 3) begin dvd = 24'h8A8A8A; dvs = 24'hEEEEEE; start = 1'b1; end
      #1;
      if (n < 20) check(take == 1'b0, "R6 late request refused", take, 0);
      else begin
        check(take == 1'b1, "R6 taken on result cycle", take, 1);
        check_q(24'hC90FDB, 24'hADF854, "R2 lone quotient");
      end
    end
    @(negedge clk); start = 1'b0;
    repeat (19) @(negedge clk);
    check(done == 1'b1, "R6 late request result", done, 1);
    check_q(24'h8A8A8A, 24'hEEEEEE, "R6 late quotient");

    // R1: reset during a division abandons it
    @(negedge clk); dvd = 24'hD00000; dvs = 24'h880000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    seen = 1'b0;
    for (int n = 0; n < 25; n++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen == 1'b0, "R1 no result after mid-flight reset", seen, 0);
    check(quotient == '0, "R1 quotient cleared", quotient, 0);
    do_single(24'hFEDCBA, 24'h812345);

    summary();
    $finish;
  end
endmodule